// File: doc/BRIEF.md
# Static Dual-Issue Pair Checker

This block sits between fetch and the two execution pipes of an in-order dual-issue core. Each cycle fetch presents a 64-bit word that holds two 32-bit instructions, already pre-decoded. The left slot always feeds the integer pipe and the right slot feeds the floating-point pipe. The block decides whether both slots issue, only the left slot issues, or nothing issues. It also tells fetch when the current word has been fully consumed.

Issue is strictly in order. The right slot never issues ahead of the left slot, and it never issues instead of it. A right slot that cannot go with its partner is held and issued alone on the next cycle, before the next word is accepted. The block remembers the loads issued in the previous cycle, because a load result can be used no earlier than one cycle after the load issues. Any instruction that reads that result in the following cycle is stalled. The result is also unavailable to the right half of the load's own pair.

Register indices use one namespace of `RW` bits. With the default of 6 bits, indices 0 to 31 are integer registers and 32 to 63 are floating-point registers. Index 0 is the hardwired zero register: it never creates a dependency, and a load that targets it is not tracked.

Top module: `pair_issue`

## Requirements
- R1: While `rst` is high, `iss_l`, `iss_r` and `fetch_adv` are low. Reset clears the record of pending loads and returns the block to pair mode, so the first word after reset can issue both slots.
- R2: In pair mode, with `in_valid` high, no flush, no hazard and `r_fp` high, both slots issue in the same cycle and `fetch_adv` is high.
- R3: In pair mode the right slot issues only in a cycle where the left slot also issues. If the left slot stalls, nothing issues and `fetch_adv` is low.
- R4: Suppose a load with a nonzero destination issued in the previous cycle. An instruction in either slot that reads that destination through `l_rs1`/`l_rs2` or `r_rs1`/`r_rs2` does not issue this cycle. It can issue one cycle later. This holds whether the load issued from the left slot or from a held right slot.
- R5: When only the left slot issues, `fetch_adv` stays low. On the next cycle the right instruction of the same word is issued alone on `iss_r`, with `iss_l` low, and `fetch_adv` goes high in that cycle.
- R6: A right slot with `r_fp` low (not floating-point class) is never paired. The left slot issues alone, and the right instruction follows as a single instruction.
- R7: A right slot that reads the left slot's nonzero destination `l_rd` does not issue in the same cycle as the left slot.
- R8: A left-slot load whose destination is a floating-point register pairs with an independent floating-point operation in the right slot. Both issue together.
- R9: While `flush` is high, nothing issues and `fetch_adv` equals `in_valid`, which drops the word. A right instruction that is being held is discarded, so the next word starts in pair mode.
- R10: Register index 0 never causes a load-use or same-pair stall.
- R11: With `in_valid` low and no flush, nothing issues and `fetch_adv` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Drop the presented word and any held right instruction |
| in_valid | input | 1 | Fetch word present |
| l_rs1 | input | RW | Left slot first source index |
| l_rs2 | input | RW | Left slot second source index |
| l_rd | input | RW | Left slot destination index (0 = none) |
| l_ld | input | 1 | Left slot is a load |
| r_fp | input | 1 | Right slot is floating-point class |
| r_rs1 | input | RW | Right slot first source index |
| r_rs2 | input | RW | Right slot second source index |
| r_rd | input | RW | Right slot destination index (0 = none) |
| r_ld | input | 1 | Right slot is a load |
| iss_l | output | 1 | Left slot issues this cycle |
| iss_r | output | 1 | Right slot issues this cycle |
| fetch_adv | output | 1 | Current fetch word is consumed |

## Verification
The block keeps three pieces of state: the single/pair mode flag and the two pending-load records. Each of them reaches the ports in the cycle right after it is written. If the mode flag is wrong, a held right instruction is either lost or issued twice. That shows as a wrong `iss_l`/`iss_r`/`fetch_adv` pattern on the next cycle. If a load record is stale or missing, a dependent instruction either slips through or is stalled when it should not be. That also shows one cycle after the load. For this reason the vectors follow every load, held slot and flush with the cycle that depends on it.

// File: rtl/pair_issue.sv
module pair_issue #(
  parameter int RW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          in_valid,
  input  logic [RW-1:0] l_rs1,
  input  logic [RW-1:0] l_rs2,
  input  logic [RW-1:0] l_rd,
  input  logic          l_ld,
  input  logic          r_fp,
  input  logic [RW-1:0] r_rs1,
  input  logic [RW-1:0] r_rs2,
  input  logic [RW-1:0] r_rd,
  input  logic          r_ld,
  output logic          iss_l,
  output logic          iss_r,
  output logic          fetch_adv
);

  localparam logic [RW-1:0] ZERO = '0;

  logic          single_q;
  logic          ldv_l_q, ldv_r_q;
  logic [RW-1:0] ldd_l_q, ldd_r_q;

  function automatic logic pend(input logic [RW-1:0] s,
                                input logic va, input logic [RW-1:0] da,
                                input logic vb, input logic [RW-1:0] db);
    return (s != ZERO) && ((va && s == da) || (vb && s == db));
  endfunction

  logic go, l_haz, r_haz, r_dep, pair_ok;

  assign go    = !rst && in_valid && !flush;
  assign l_haz = pend(l_rs1, ldv_l_q, ldd_l_q, ldv_r_q, ldd_r_q) ||
                 pend(l_rs2, ldv_l_q, ldd_l_q, ldv_r_q, ldd_r_q);
  assign r_haz = pend(r_rs1, ldv_l_q, ldd_l_q, ldv_r_q, ldd_r_q) ||
                 pend(r_rs2, ldv_l_q, ldd_l_q, ldv_r_q, ldd_r_q);
  assign r_dep = (l_rd != ZERO) && (r_rs1 == l_rd || r_rs2 == l_rd);
  assign pair_ok = r_fp && !r_dep && !r_haz;

  assign iss_l = go && !single_q && !l_haz;
  assign iss_r = single_q ? (go && !r_haz) : (iss_l && pair_ok);
  assign fetch_adv = !rst && (flush ? in_valid : iss_r);

  always_ff @(posedge clk) begin
    if (rst) begin
      single_q <= 1'b0;
      ldv_l_q  <= 1'b0;
      ldv_r_q  <= 1'b0;
      ldd_l_q  <= '0;
      ldd_r_q  <= '0;
    end else begin
      if (flush)
        single_q <= 1'b0;
      else if (iss_l && !iss_r)
        single_q <= 1'b1;
      else if (iss_r)
        single_q <= 1'b0;
      ldv_l_q <= iss_l && l_ld && (l_rd != ZERO);
      ldv_r_q <= iss_r && r_ld && (r_rd != ZERO);
      ldd_l_q <= l_rd;
      ldd_r_q <= r_rd;
    end
  end

endmodule

// File: rtl/pair_issue_chk.sv
module pair_issue_chk #(
  parameter int RW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          flush,
  input logic          in_valid,
  input logic [RW-1:0] l_rs1,
  input logic [RW-1:0] l_rs2,
  input logic [RW-1:0] l_rd,
  input logic          l_ld,
  input logic [RW-1:0] r_rs1,
  input logic [RW-1:0] r_rs2,
  input logic          iss_l,
  input logic          iss_r,
  input logic          fetch_adv,
  input logic          single_q
);

  AST_RIGHT_NEEDS_LEFT: assert property (@(posedge clk) disable iff (rst)
    (!single_q && iss_r) |-> iss_l); // R3

  AST_HELD_ALONE: assert property (@(posedge clk) disable iff (rst)
    single_q |-> !iss_l); // R5

  AST_HOLD_AFTER_SPLIT: assert property (@(posedge clk) disable iff (rst)
    (iss_l && !iss_r && !flush) |-> (!fetch_adv ##1 single_q)); // R5

  AST_LOAD_USE_GAP: assert property (@(posedge clk) disable iff (rst)
    ($past(iss_l && l_ld && l_rd != '0) && iss_l) |->
      (l_rs1 != $past(l_rd) && l_rs2 != $past(l_rd))); // R4

  AST_SAME_PAIR_RAW: assert property (@(posedge clk) disable iff (rst)
    (!single_q && iss_r && l_rd != '0) |-> (r_rs1 != l_rd && r_rs2 != l_rd)); // R7

  AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (rst)
    flush |-> (!iss_l && !iss_r && fetch_adv == in_valid)); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !flush) |-> (!iss_l && !iss_r && !fetch_adv)); // R11

endmodule

bind pair_issue pair_issue_chk #(.RW(RW)) i_chk (
  .clk(clk), .rst(rst), .flush(flush), .in_valid(in_valid),
  .l_rs1(l_rs1), .l_rs2(l_rs2), .l_rd(l_rd), .l_ld(l_ld),
  .r_rs1(r_rs1), .r_rs2(r_rs2),
  .iss_l(iss_l), .iss_r(iss_r), .fetch_adv(fetch_adv),
  .single_q(single_q)
);

// File: tb/test_pair_issue.sv
module test_pair_issue;
  localparam int RW = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic flush = 1'b0, in_valid = 1'b0, l_ld = 1'b0, r_fp = 1'b0, r_ld = 1'b0;
  logic [RW-1:0] l_rs1 = '0, l_rs2 = '0, l_rd = '0, r_rs1 = '0, r_rs2 = '0, r_rd = '0;
  logic iss_l, iss_r, fetch_adv;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  pair_issue #(.RW(RW)) i_pair_issue (
    .clk(clk), .rst(rst), .flush(flush), .in_valid(in_valid),
    .l_rs1(l_rs1), .l_rs2(l_rs2), .l_rd(l_rd), .l_ld(l_ld),
    .r_fp(r_fp), .r_rs1(r_rs1), .r_rs2(r_rs2), .r_rd(r_rd), .r_ld(r_ld),
    .iss_l(iss_l), .iss_r(iss_r), .fetch_adv(fetch_adv)
  );

  typedef struct packed {
    logic fl, v;
    logic [RW-1:0] a1, a2, ad;
    logic ald, bfp;
    logic [RW-1:0] b1, b2, bd;
    logic bld, el, er, ea;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t TBL [NV] = '{
    '{0,0, 0,0,0,0, 0, 0,0,0,0, 0,0,0, 11}, // R11 idle
    '{0,1, 1,2,3,0, 1, 33,34,40,0, 1,1,1, 2}, // R2 clean pair
    '{0,1, 1,0,40,1, 1, 42,43,41,0, 1,1,1, 8}, // R8 fp load + fp op
    '{0,1, 5,6,7,0, 1, 40,33,44,0, 1,0,0, 4}, // R4 right uses load
    '{0,1, 5,6,7,0, 1, 40,33,44,0, 0,1,1, 5}, // R5 held right alone
    '{0,1, 1,0,8,1, 1, 8,33,45,0, 1,0,0, 7}, // R7 same-pair RAW
    '{0,1, 1,0,8,1, 1, 8,33,45,0, 0,0,0, 4}, // R4 held right stalls
    '{0,1, 1,0,8,1, 1, 8,33,45,0, 0,1,1, 5}, // R5 held right goes
    '{0,1, 1,2,11,0, 0, 33,34,44,0, 1,0,0, 6}, // R6 right not fp
    '{0,1, 1,2,11,0, 0, 33,34,44,0, 0,1,1, 6}, // R6 follows alone
    '{0,1, 1,0,9,1, 1, 33,34,45,0, 1,1,1, 2}, // R2 int load pair
    '{0,1, 9,2,12,0, 1, 33,34,46,0, 0,0,0, 3}, // R3 left stalls, none
    '{0,1, 9,2,12,0, 1, 33,34,46,0, 1,1,1, 3}, // R3 then both
    '{0,1, 1,0,0,1, 1, 33,34,46,0, 1,1,1, 10}, // R10 load to r0
    '{0,1, 0,0,0,0, 1, 0,33,46,0, 1,1,1, 10}, // R10 read r0
    '{1,1, 1,2,3,0, 1, 33,34,40,0, 0,0,1, 9}, // R9 flush drops
    '{0,1, 1,2,13,0, 0, 33,34,47,0, 1,0,0, 6}, // R6 split
    '{1,1, 1,2,13,0, 0, 33,34,47,0, 0,0,1, 9}, // R9 flush held
    '{0,1, 1,2,14,0, 1, 33,34,47,0, 1,1,1, 9}, // R9 pair mode again
    '{0,1, 1,2,15,0, 0, 33,34,10,1, 1,0,0, 6}, // R6 split, right load
    '{0,1, 1,2,15,0, 0, 33,34,10,1, 0,1,1, 5}, // R5 right load alone
    '{0,1, 10,2,16,0, 1, 33,34,48,0, 0,0,0, 4}, // R4 use of right load
    '{0,1, 10,2,16,0, 1, 33,34,48,0, 1,1,1, 4}  // R4 one cycle later
  };

  task automatic drive(input vec_t t);
    @(negedge clk);
    flush = t.fl; in_valid = t.v;
    l_rs1 = t.a1; l_rs2 = t.a2; l_rd = t.ad; l_ld = t.ald;
    r_fp = t.bfp; r_rs1 = t.b1; r_rs2 = t.b2; r_rd = t.bd; r_ld = t.bld;
    #5;
  endtask

  task automatic expect3(input logic el, input logic er, input logic ea, input string tag);
    checks++;
    if ({iss_l, iss_r, fetch_adv} !== {el, er, ea}) begin
      errors++;
      $display("FAIL %s: got l/r/adv=%b%b%b expected %b%b%b", tag,
               iss_l, iss_r, fetch_adv, el, er, ea);
    end
  endtask

  function automatic vec_t mk(input logic [RW-1:0] a1, input logic [RW-1:0] ad,
                              input logic ald, input logic bfp);
    vec_t t = '0;
    t.v = 1'b1; t.a1 = a1; t.ad = ad; t.ald = ald; t.bfp = bfp;
    t.b1 = 6'd33; t.b2 = 6'd34; t.bd = 6'd50;
    return t;
  endfunction

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    drive(mk(6'd1, 6'd3, 1'b0, 1'b1));
    expect3(0, 0, 0, "R1 outputs low in reset");
    drive(mk(6'd1, 6'd3, 1'b0, 1'b1));
    rst = 1'b0;
    #1;
    expect3(1, 1, 1, "R1 first word after reset");

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i]);
      expect3(TBL[i].el, TBL[i].er, TBL[i].ea, $sformatf("R%0d row %0d", TBL[i].req, i));
    end

    drive(mk(6'd1, 6'd20, 1'b0, 1'b0));
    expect3(1, 0, 0, "R6 split before reset");
    drive(mk(6'd1, 6'd20, 1'b0, 1'b0));
    rst = 1'b1;
    #1;
    expect3(0, 0, 0, "R1 reset overrides held slot");
    drive(mk(6'd1, 6'd21, 1'b0, 1'b1));
    rst = 1'b0;
    #1;
    expect3(1, 1, 1, "R1 reset clears held slot");

    drive(mk(6'd1, 6'd22, 1'b1, 1'b1));
    expect3(1, 1, 1, "R2 load pair before reset");
    drive(mk(6'd22, 6'd23, 1'b0, 1'b1));
    rst = 1'b1;
    #1;
    expect3(0, 0, 0, "R1 reset with load pending");
    drive(mk(6'd22, 6'd23, 1'b0, 1'b1));
    rst = 1'b0;
    #1;
    expect3(1, 1, 1, "R1 reset clears pending load");

    drive(mk(6'd1, 6'd24, 1'b1, 1'b1));
    expect3(1, 1, 1, "R2 load pair");
    drive(mk(6'd2, 6'd25, 1'b0, 1'b1));
    expect3(1, 1, 1, "R4 unrelated source not stalled");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule